// File: doc/BRIEF.md
# SIMD Floating-Point Control and Status Register

This block holds the 32-bit control and status word of a SIMD floating-point unit. Software writes it through a write port and reads it back on a read port. The arithmetic units report exceptions on a separate input. Those reports collect in six sticky status flags, and only a software write can clear the flags again. The control fields are decoded and driven straight to the datapath:
- rounding mode
- denormal operands read as zero
- flush of masked underflow results to zero
- mask for misaligned accesses

A fault output goes high whenever a set status flag has its matching mask bit clear. The trap logic downstream uses this output.

A software write is accepted only when every set bit of its data lies inside a parameterised valid-bit mask. Any other write is dropped and raises a one-cycle error pulse.

Top module: `simd_fpcsr`

## Requirements
- R1: After reset the register reads 0x00001F80: the six mask bits 12:7 are set and every other bit is zero.
- R2: A write whose data has no bit outside VALID_MASK (default 0x0002FFFF) is stored, and the value is visible on `rd_data` in the cycle after the write.
- R3: A write whose data sets any bit outside VALID_MASK leaves the register unchanged. `wr_err` is then high for exactly the one cycle after that write.
- R4: When `rep_valid` is high, `rep_flags[5:0]` is ORed into register bits 5:0. Report bits 7:6 and all register bits above 5 are unaffected.
- R5: Status flags are sticky: hardware never clears a set bit in 5:0. Only an accepted software write can clear one.
- R6: When an accepted write and a report arrive in the same cycle, the stored value is the write data ORed with `rep_flags[5:0]`.
- R7: The decoded outputs follow the register fields:
  - `round_mode` is bits 14:13.
  - `daz` is bit 6.
  - `ftz` is bit 15.
  - `misalign_mask` is bit 17.
- R8: `fault` is high exactly when some flag bit i (i = 0..5) is set while mask bit i+7 is clear.
- R9: Bit 16 and bits 31:18 always read as zero.
- R10: `wr_err` is never high unless a write was requested in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write request |
| wr_data | input | 32 | Software write data |
| rep_valid | input | 1 | Exception report from the datapath is valid |
| rep_flags | input | 8 | Exception report; only bits 5:0 are used |
| rd_data | output | 32 | Current register value |
| round_mode | output | 2 | Rounding mode code |
| daz | output | 1 | Denormal operands treated as zero |
| ftz | output | 1 | Flush masked underflow to zero |
| misalign_mask | output | 1 | Misaligned-access exception mask |
| fault | output | 1 | An unmasked exception flag is set |
| wr_err | output | 1 | One-cycle pulse after a rejected write |

## Verification
The hardest case to reach from the ports is a cycle where a write and a report collide. This matters most when the write is rejected: the report must still land on top of the old value, while the write data must leave no trace. The bench drives a rejected write and a report in the same cycle, then checks both `rd_data` and `wr_err`. The fault output is swept over all 4096 combinations of flags and masks, each loaded by an accepted write.

// File: rtl/simd_fpcsr_pkg.sv
package simd_fpcsr_pkg;
  localparam int CSR_W      = 32;
  localparam int NUM_FLAGS  = 6;
  localparam int FLAG_LO    = 0;
  localparam int DAZ_POS    = 6;
  localparam int MASK_LO    = 7;
  localparam int RND_LO     = 13;
  localparam int RND_W      = 2;
  localparam int FTZ_POS    = 15;
  localparam int MISAL_POS  = 17;
  localparam logic [CSR_W-1:0] CSR_RESET   = 32'h0000_1F80;
  localparam logic [CSR_W-1:0] CSR_VALID_D = 32'h0002_FFFF;

  typedef struct packed {
    logic [RND_W-1:0]     rnd;
    logic                 daz;
    logic                 ftz;
    logic                 misal;
    logic [NUM_FLAGS-1:0] flags;
    logic [NUM_FLAGS-1:0] masks;
  } csr_fields_t;
endpackage

// File: rtl/fpcsr_wr_filter.sv
module fpcsr_wr_filter #(
  parameter int                  W     = 32,
  parameter logic [W-1:0]        VALID = '1
) (
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         accept,
  output logic         reject
);
  logic [W-1:0] illegal_bits;

  always_comb begin
    illegal_bits = wr_data & ~VALID;
    accept       = wr_en && (illegal_bits == '0);
    reject       = wr_en && (illegal_bits != '0);
  end
endmodule

// File: rtl/fpcsr_store.sv
module fpcsr_store
  import simd_fpcsr_pkg::*;
#(
  parameter int           W     = CSR_W,
  parameter int           REP_W = 8,
  parameter logic [W-1:0] VALID = CSR_VALID_D,
  parameter logic [W-1:0] RSTV  = CSR_RESET
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             rep_valid,
  input  logic [REP_W-1:0] rep_flags,
  output logic [W-1:0]     csr_q
);
  localparam int USED = (REP_W < NUM_FLAGS) ? REP_W : NUM_FLAGS;

  logic [W-1:0] base_val;
  logic [W-1:0] rep_mask;
  logic [W-1:0] next_val;

  // Report bits beyond the flag field are ignored.
  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_rep
      if (gi >= FLAG_LO && gi < FLAG_LO + USED) begin : g_used
        assign rep_mask[gi] = rep_valid & rep_flags[gi - FLAG_LO];
      end else begin : g_zero
        assign rep_mask[gi] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    base_val = accept ? wr_data : csr_q;
    next_val = base_val | rep_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) csr_q <= RSTV;
    else     csr_q <= next_val;
  end

  // R1
  a_r1_reset_value: assert property (@(posedge clk) $past(rst) |-> csr_q == RSTV);
  // R5
  a_r5_flags_sticky: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(accept)) |->
      ((csr_q[FLAG_LO +: NUM_FLAGS] & $past(csr_q[FLAG_LO +: NUM_FLAGS]))
        == $past(csr_q[FLAG_LO +: NUM_FLAGS])));
  // R3
  a_r3_reject_holds: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && !$past(accept) && !$past(rep_valid)) |-> $stable(csr_q));
  // R4
  a_r4_upper_untouched: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(accept)) |-> csr_q[W-1:NUM_FLAGS] == $past(csr_q[W-1:NUM_FLAGS]));
  // R9
  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (csr_q & ~VALID) == '0);
endmodule

// File: rtl/fpcsr_decode.sv
module fpcsr_decode
  import simd_fpcsr_pkg::*;
#(
  parameter int W = CSR_W
) (
  input  logic [W-1:0]       csr,
  output csr_fields_t        f,
  output logic               fault
);
  logic [NUM_FLAGS-1:0] unmasked;

  always_comb begin
    f.rnd   = csr[RND_LO +: RND_W];
    f.daz   = csr[DAZ_POS];
    f.ftz   = csr[FTZ_POS];
    f.misal = csr[MISAL_POS];
    f.flags = csr[FLAG_LO +: NUM_FLAGS];
    f.masks = csr[MASK_LO +: NUM_FLAGS];
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FLAGS; gi++) begin : g_unm
      assign unmasked[gi] = f.flags[gi] & ~f.masks[gi];
    end
  endgenerate

  assign fault = |unmasked;

  // R8
  a_r8_fault_needs_flag: assert final (!fault || (f.flags != '0));
endmodule

// File: rtl/simd_fpcsr.sv
module simd_fpcsr
  import simd_fpcsr_pkg::*;
#(
  parameter int               REP_W      = 8,
  parameter logic [CSR_W-1:0] VALID_MASK = CSR_VALID_D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CSR_W-1:0]  wr_data,
  input  logic              rep_valid,
  input  logic [REP_W-1:0]  rep_flags,
  output logic [CSR_W-1:0]  rd_data,
  output logic [RND_W-1:0]  round_mode,
  output logic              daz,
  output logic              ftz,
  output logic              misalign_mask,
  output logic              fault,
  output logic              wr_err
);
  logic        accept;
  logic        reject;
  logic [CSR_W-1:0] csr_q;
  csr_fields_t fld;
  logic        fault_c;
  logic        err_q;

  fpcsr_wr_filter #(.W(CSR_W), .VALID(VALID_MASK)) u_filter (
    .wr_en(wr_en), .wr_data(wr_data), .accept(accept), .reject(reject)
  );

  fpcsr_store #(.W(CSR_W), .REP_W(REP_W), .VALID(VALID_MASK), .RSTV(CSR_RESET)) u_store (
    .clk(clk), .rst(rst), .accept(accept), .wr_en(wr_en), .wr_data(wr_data),
    .rep_valid(rep_valid), .rep_flags(rep_flags), .csr_q(csr_q)
  );

  fpcsr_decode #(.W(CSR_W)) u_dec (
    .csr(csr_q), .f(fld), .fault(fault_c)
  );

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= reject;
  end

  assign rd_data       = csr_q;
  assign round_mode    = fld.rnd;
  assign daz           = fld.daz;
  assign ftz           = fld.ftz;
  assign misalign_mask = fld.misal;
  assign fault         = fault_c;
  assign wr_err        = err_q;

  // R10
  a_r10_err_after_write: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> $past(wr_en));
  // R2
  a_r2_accept_stores: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(accept) && !$past(rep_valid)) |-> rd_data == $past(wr_data));
endmodule

// File: tb/simd_fpcsr_test.sv
module simd_fpcsr_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        wr_en = 0;
  logic [31:0] wr_data = 0;
  logic        rep_valid = 0;
  logic [7:0]  rep_flags = 0;
  logic [31:0] rd_data;
  logic [1:0]  round_mode;
  logic        daz, ftz, misalign_mask, fault, wr_err;

  localparam logic [31:0] VALID = 32'h0002_FFFF;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] mdl;

  simd_fpcsr uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rep_valid(rep_valid), .rep_flags(rep_flags), .rd_data(rd_data),
    .round_mode(round_mode), .daz(daz), .ftz(ftz), .misalign_mask(misalign_mask),
    .fault(fault), .wr_err(wr_err)
  );

  always #10 clk = ~clk;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      finish_run();
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic exp_fault(logic [31:0] v);
    logic f = 0;
    for (int i = 0; i < 6; i++) if (v[i] && !v[i+7]) f = 1;
    return f;
  endfunction

  // Drive one cycle of stimulus, update the model, check all outputs after the edge.
  task automatic apply(logic we, logic [31:0] wd, logic rv, logic [7:0] rf, string req);
    logic ok;
    logic exp_err;
    @(negedge clk);
    wr_en = we; wr_data = wd; rep_valid = rv; rep_flags = rf;
    ok = we && ((wd & ~VALID) == 0);
    exp_err = we && !ok;
    if (ok) mdl = wd;
    if (rv) mdl = mdl | {26'd0, rf[5:0]};
    @(negedge clk);
    chk(req, rd_data, mdl);
    chk("R3", {31'd0, wr_err}, {31'd0, exp_err});
    chk("R8", {31'd0, fault}, {31'd0, exp_fault(mdl)});
    chk("R7", {27'd0, round_mode, daz, ftz, misalign_mask}, {27'd0, mdl[14:13], mdl[6], mdl[15], mdl[17]});
    chk("R9", rd_data & ~VALID, 32'd0);
    wr_en = 0; rep_valid = 0; wr_data = 0; rep_flags = 0;
  endtask

  initial begin
    mdl = 32'h1F80;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1", rd_data, 32'h0000_1F80);
    chk("R8", {31'd0, fault}, 32'd0);
    chk("R10", {31'd0, wr_err}, 32'd0);

    // R8 / R2: all flag and mask combinations loaded by writes
    for (int v = 0; v < 4096; v++)
      apply(1, (32'(v >> 6) << 7) | 32'(v & 63), 0, 0, "R2");

    // R7: control field sweep
    for (int c = 0; c < 32; c++)
      apply(1, (32'(c & 3) << 13) | (32'((c >> 2) & 1) << 6) |
               (32'((c >> 3) & 1) << 15) | (32'((c >> 4) & 1) << 17) | 32'h1F80, 0, 0, "R7");

    // R3 / R9: single-bit writes across all positions
    for (int b = 0; b < 32; b++) begin
      apply(1, 32'h1F80, 0, 0, "R2");
      apply(1, 32'h1F80 | (32'd1 << b), 0, 0, "R3");
    end

    // R10: idle cycles after a rejected write
    apply(1, 32'h8000_0000, 0, 0, "R3");
    apply(0, 0, 0, 0, "R10");

    // R4 / R5: sticky accumulation, report bits 7:6 ignored
    apply(1, 32'h0000_1F80, 0, 0, "R2");
    for (int r = 0; r < 256; r++) begin
      if ((r % 16) == 0) apply(1, 32'h0000_1F80 | 32'(r & 32'h6000), 0, 0, "R5");
      apply(0, 0, 1, 8'(r), "R4");
      apply(0, 0, 0, 0, "R5");
    end
    apply(1, 32'h0000_1F80, 0, 0, "R2");
    apply(0, 0, 1, 8'hC0, "R4");

    // R6: write and report together
    apply(1, 32'h0000_0001, 1, 8'h22, "R6");
    apply(1, 32'h0000_6F80, 1, 8'hFF, "R6");
    // rejected write with report: report lands on old value
    apply(1, 32'h0001_0000, 1, 8'h04, "R6");
    apply(1, 32'hFFFF_FFFF, 1, 8'h10, "R3");

    finish_run();
  end
endmodule